// File: doc/BRIEF.md
# Taint-aware branch resolution controller

This block stands between the branch execution units and the fetch front end of an out-of-order core. Every resolved branch is reported to it with its age, its program counter, the correct next fetch address, whether it was taken and whether it was mispredicted. Each report also says whether the branch predicate and the branch target still depend on speculatively loaded data, and names the youngest load each of them depends on (its taint root). The block holds such branches in a small table. It releases predictor training and misprediction redirects only when the data they carry can no longer depend on speculative loads, so the fetch stream never reflects values that might be squashed.

A visibility notification carries a root number. Every pending predicate or target whose root is at or below that number becomes clean. Each cycle the oldest clean pending branch is issued. Its predictor update always goes out. If it was mispredicted, a squash and redirect also goes out, and every younger pending branch is discarded without training. An external flush empties the table. Tainted older branches never hold back a younger clean one.

Top module: `taint_branch_resolver`

## Requirements
- R1: While reset is high, and in the first cycle after it, no update and no squash are presented.
- R2: A branch sends its predictor update only once both its predicate and its target are clean. A taint flag of 1 means tainted.
- R3: A mispredicted branch whose predicate is tainted raises no squash until a visibility notification clears its predicate.
- R4: A clean mispredicted branch squashes even while an older branch with a tainted predicate is still pending. That older branch stays pending and later issues on its own.
- R5: A squash discards every pending branch younger than the squashing one, tainted or clean, and those branches never send an update.
- R6: Age order is unsigned: a smaller age is older. At most one branch issues per cycle, always the oldest clean pending one, so updates leave in age order.
- R7: A squash is always accompanied, in the same cycle, by the predictor update of the same branch, carrying its pc, taken flag and next address.
- R8: A flush discards all pending branches and blocks any update or squash in that cycle. Discarded branches never train the predictors.
- R9: A branch resolved clean in cycle k and still oldest issues its outputs in the registered output of cycle k+1, two clock edges after its inputs are sampled.
- R10: A visibility notification with root V cleans every taint whose root is less than or equal to V, including one arriving on a resolve in the same cycle.
- R11: A resolve that arrives in the same cycle as a squash and is younger than the squashing branch is dropped.
- R12: The table holds DEPTH branches. The resolve source never presents a branch while all DEPTH entries are occupied, except together with a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A branch resolution is presented |
| res_age | input | AGE_W | Age of the branch; a smaller value is older |
| res_pc | input | ADDR_W | Branch program counter |
| res_next | input | ADDR_W | Correct next fetch address |
| res_taken | input | 1 | Resolved direction |
| res_mispred | input | 1 | The prediction was wrong |
| res_pred_tainted | input | 1 | The predicate depends on speculative data |
| res_pred_root | input | ROOT_W | Youngest load feeding the predicate |
| res_tgt_tainted | input | 1 | The target depends on speculative data |
| res_tgt_root | input | ROOT_W | Youngest load feeding the target |
| vis_valid | input | 1 | Visibility point advanced |
| vis_root | input | ROOT_W | Roots at or below this value are now safe |
| flush | input | 1 | Discard all pending branches |
| upd_valid | output | 1 | Predictor training request |
| upd_pc | output | ADDR_W | PC to train |
| upd_taken | output | 1 | Direction to train |
| upd_next | output | ADDR_W | Target to train |
| sq_valid | output | 1 | Squash and redirect request |
| sq_age | output | AGE_W | Age of the squashing branch |
| sq_next | output | ADDR_W | Redirect address |

## Verification
The bench holds several tainted branches and then releases them with one visibility notification. A design that issued by slot position instead of age would train out of order, and one that let tainted entries win selection would train on speculative data. It places a clean mispredict behind an older tainted one to catch a design that stalls on the oldest entry. It also places tainted doomed branches behind a clean squash, where a design that kept them would train them once their taint later clears. Same-cycle races are driven on purpose: a resolve younger than a squash arriving with it, a flush against a ready entry, and a resolve whose root is cleared in its own cycle. Random traffic then mixes all of these with a full table.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  // Per-branch status bits held alongside each pending entry.
  typedef struct packed {
    logic taken;
    logic mispred;
    logic pred_taint;
    logic tgt_taint;
  } br_flags_t;

endpackage

// File: rtl/tbr_entry.sv
module tbr_entry
  import tbr_pkg::*;
#(
  parameter int AGE_W  = 6,
  parameter int ROOT_W = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [AGE_W-1:0]  load_age,
  input  logic [ADDR_W-1:0] load_pc,
  input  logic [ADDR_W-1:0] load_next,
  input  br_flags_t         load_flags,
  input  logic [ROOT_W-1:0] load_proot,
  input  logic [ROOT_W-1:0] load_troot,
  input  logic              vis_valid,
  input  logic [ROOT_W-1:0] vis_root,
  input  logic              drop,
  output logic              valid_o,
  output logic [AGE_W-1:0]  age_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] next_o,
  output br_flags_t         flags_o,
  output logic              clean_o
);

  logic              valid_q;
  logic [AGE_W-1:0]  age_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] next_q;
  br_flags_t         flags_q;
  logic [ROOT_W-1:0] proot_q;
  logic [ROOT_W-1:0] troot_q;

  // A root at or below the visibility point is no longer speculative.
  logic in_pred_safe, in_tgt_safe, st_pred_safe, st_tgt_safe;
  assign in_pred_safe = vis_valid && (load_proot <= vis_root);
  assign in_tgt_safe  = vis_valid && (load_troot <= vis_root);
  assign st_pred_safe = vis_valid && (proot_q <= vis_root);
  assign st_tgt_safe  = vis_valid && (troot_q <= vis_root);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (drop) begin
      valid_q <= 1'b0;
    end else if (load_en) begin
      valid_q            <= 1'b1;
      flags_q.taken      <= load_flags.taken;
      flags_q.mispred    <= load_flags.mispred;
      flags_q.pred_taint <= load_flags.pred_taint && !in_pred_safe;
      flags_q.tgt_taint  <= load_flags.tgt_taint && !in_tgt_safe;
    end else if (valid_q) begin
      if (st_pred_safe) flags_q.pred_taint <= 1'b0;
      if (st_tgt_safe)  flags_q.tgt_taint  <= 1'b0;
    end
  end

  // Payload needs no reset: it is only read while valid_q is set.
  always_ff @(posedge clk) begin
    if (load_en && !drop) begin
      age_q   <= load_age;
      pc_q    <= load_pc;
      next_q  <= load_next;
      proot_q <= load_proot;
      troot_q <= load_troot;
    end
  end

  assign valid_o = valid_q;
  assign age_o   = age_q;
  assign pc_o    = pc_q;
  assign next_o  = next_q;
  assign flags_o = flags_q;
  assign clean_o = valid_q && !flags_q.pred_taint && !flags_q.tgt_taint;

endmodule

// File: rtl/tbr_oldest_pick.sv
module tbr_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int AGE_W = 6,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][AGE_W-1:0] ages,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);

  logic [AGE_W-1:0] best;

  // Smallest age among the candidates wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || ages[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = ages[i];
      end
    end
  end

endmodule

// File: rtl/tbr_slot_alloc.sv
module tbr_slot_alloc #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] occupied,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);

  // Lowest empty slot; scanning downward lets the lowest index win.
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occupied[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/taint_branch_resolver.sv
module taint_branch_resolver
  import tbr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 6,
  parameter int ROOT_W = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [AGE_W-1:0]  res_age,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_next,
  input  logic              res_taken,
  input  logic              res_mispred,
  input  logic              res_pred_tainted,
  input  logic [ROOT_W-1:0] res_pred_root,
  input  logic              res_tgt_tainted,
  input  logic [ROOT_W-1:0] res_tgt_root,
  input  logic              vis_valid,
  input  logic [ROOT_W-1:0] vis_root,
  input  logic              flush,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_pc,
  output logic              upd_taken,
  output logic [ADDR_W-1:0] upd_next,
  output logic              sq_valid,
  output logic [AGE_W-1:0]  sq_age,
  output logic [ADDR_W-1:0] sq_next
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            ent_valid;
  logic [DEPTH-1:0]            ent_clean;
  logic [DEPTH-1:0]            ent_load;
  logic [DEPTH-1:0]            ent_drop;
  logic [DEPTH-1:0][AGE_W-1:0] ent_age;
  logic [ADDR_W-1:0]           ent_pc   [DEPTH];
  logic [ADDR_W-1:0]           ent_next [DEPTH];
  br_flags_t                   ent_flags[DEPTH];

  br_flags_t        in_flags;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  logic              issue;
  logic              squash_now;
  logic              accept;
  logic [AGE_W-1:0]  sel_age;
  logic [ADDR_W-1:0] sel_pc;
  logic [ADDR_W-1:0] sel_next;
  br_flags_t         sel_flags;

  assign in_flags = {res_taken, res_mispred, res_pred_tainted, res_tgt_tainted};

  // Selection: oldest entry whose predicate and target are both clean.
  tbr_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .cand  (ent_clean),
    .ages  (ent_age),
    .found (pick_found),
    .idx   (pick_idx)
  );

  tbr_slot_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .occupied (ent_valid),
    .free_any (free_any),
    .free_idx (free_idx)
  );

  assign sel_age    = ent_age[pick_idx];
  assign sel_pc     = ent_pc[pick_idx];
  assign sel_next   = ent_next[pick_idx];
  assign sel_flags  = ent_flags[pick_idx];

  assign issue      = pick_found && !flush;
  assign squash_now = issue && sel_flags.mispred;
  // A resolve on the wrong side of a same-cycle squash is discarded.
  assign accept     = res_valid && !flush && free_any &&
                      !(squash_now && (res_age > sel_age));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic younger;
    assign younger     = ent_valid[g] && (ent_age[g] > sel_age);
    assign ent_drop[g] = flush ||
                         (issue && (pick_idx == IDX_W'(g))) ||
                         (squash_now && younger);
    assign ent_load[g] = accept && (free_idx == IDX_W'(g));

    tbr_entry #(.AGE_W(AGE_W), .ROOT_W(ROOT_W), .ADDR_W(ADDR_W)) u_entry (
      .clk        (clk),
      .rst        (rst),
      .load_en    (ent_load[g]),
      .load_age   (res_age),
      .load_pc    (res_pc),
      .load_next  (res_next),
      .load_flags (in_flags),
      .load_proot (res_pred_root),
      .load_troot (res_tgt_root),
      .vis_valid  (vis_valid),
      .vis_root   (vis_root),
      .drop       (ent_drop[g]),
      .valid_o    (ent_valid[g]),
      .age_o      (ent_age[g]),
      .pc_o       (ent_pc[g]),
      .next_o     (ent_next[g]),
      .flags_o    (ent_flags[g]),
      .clean_o    (ent_clean[g])
    );
  end

  // Registered requests toward the front end.
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      sq_valid  <= 1'b0;
    end else begin
      upd_valid <= issue;
      sq_valid  <= squash_now;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      upd_pc    <= sel_pc;
      upd_taken <= sel_flags.taken;
      upd_next  <= sel_next;
      sq_age    <= sel_age;
      sq_next   <= sel_next;
    end
  end

endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int DEPTH = 8,
  parameter int AGE_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             res_valid,
  input logic [DEPTH-1:0] ent_valid,
  input logic             upd_valid,
  input logic             sq_valid,
  input logic [AGE_W-1:0] sq_age
);

  // R1: reset leaves the request outputs quiet on the following cycle.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!upd_valid && !sq_valid));

  // R7: every squash carries the training update of the same branch.
  assert_squash_trains_R7: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> upd_valid);

  // R8: a flush blocks both requests of its cycle.
  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!upd_valid && !sq_valid));

  // R5 / R11: nothing younger than a squash survives to squash next cycle.
  assert_no_younger_squash_R5: assert property (@(posedge clk) disable iff (rst)
    sq_valid |=> !(sq_valid && (sq_age > $past(sq_age))));

  // R12: no resolve is presented into a full table.
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    ((&ent_valid) && !flush) |-> !res_valid);

endmodule

bind taint_branch_resolver tbr_checker #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_tbr_checker (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .res_valid (res_valid),
  .ent_valid (ent_valid),
  .upd_valid (upd_valid),
  .sq_valid  (sq_valid),
  .sq_age    (sq_age)
);

// File: tb/test_taint_branch_resolver.sv
`timescale 1ns/1ps
module test_taint_branch_resolver;

  localparam int DEPTH  = 8;
  localparam int AGE_W  = 6;
  localparam int ROOT_W = 6;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              res_valid = 1'b0;
  logic [AGE_W-1:0]  res_age = '0;
  logic [ADDR_W-1:0] res_pc = '0;
  logic [ADDR_W-1:0] res_next = '0;
  logic              res_taken = 1'b0;
  logic              res_mispred = 1'b0;
  logic              res_pred_tainted = 1'b0;
  logic [ROOT_W-1:0] res_pred_root = '0;
  logic              res_tgt_tainted = 1'b0;
  logic [ROOT_W-1:0] res_tgt_root = '0;
  logic              vis_valid = 1'b0;
  logic [ROOT_W-1:0] vis_root = '0;
  logic              flush = 1'b0;
  logic              upd_valid, upd_taken, sq_valid;
  logic [ADDR_W-1:0] upd_pc, upd_next, sq_next;
  logic [AGE_W-1:0]  sq_age;

  taint_branch_resolver #(.DEPTH(DEPTH), .AGE_W(AGE_W), .ROOT_W(ROOT_W), .ADDR_W(ADDR_W))
    i_taint_branch_resolver (
      .clk(clk), .rst(rst), .res_valid(res_valid), .res_age(res_age), .res_pc(res_pc),
      .res_next(res_next), .res_taken(res_taken), .res_mispred(res_mispred),
      .res_pred_tainted(res_pred_tainted), .res_pred_root(res_pred_root),
      .res_tgt_tainted(res_tgt_tainted), .res_tgt_root(res_tgt_root),
      .vis_valid(vis_valid), .vis_root(vis_root), .flush(flush),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_next(upd_next),
      .sq_valid(sq_valid), .sq_age(sq_age), .sq_next(sq_next));

  always #4 clk = ~clk;   // 125 MHz

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    primed = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Bench model of the pending table, written from the requirements.
  bit                m_v  [DEPTH];
  logic [AGE_W-1:0]  m_age[DEPTH];
  logic [ADDR_W-1:0] m_pc [DEPTH];
  logic [ADDR_W-1:0] m_nx [DEPTH];
  bit                m_tk [DEPTH];
  bit                m_mp [DEPTH];
  bit                m_pt [DEPTH];
  bit                m_tt [DEPTH];
  logic [ROOT_W-1:0] m_pr [DEPTH];
  logic [ROOT_W-1:0] m_tr [DEPTH];

  bit                e_upd = 1'b0, e_tk = 1'b0, e_sq = 1'b0;
  logic [ADDR_W-1:0] e_pc = '0, e_nx = '0;
  logic [AGE_W-1:0]  e_sqage = '0;

  function automatic int model_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[i]) c++;
    return c;
  endfunction

  function automatic bit age_busy(input logic [AGE_W-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_age[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step();
    int   sel, free_slot, cnt;
    bit   found;
    logic [AGE_W-1:0] sage;
    sel = 0; found = 1'b0; sage = '0; free_slot = -1; cnt = 0;
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      e_upd = 1'b0; e_sq = 1'b0;
      return;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i]) cnt++;
      else if (free_slot < 0) free_slot = i;
      if (m_v[i] && !m_pt[i] && !m_tt[i] && (!found || m_age[i] < sage)) begin
        found = 1'b1; sel = i; sage = m_age[i];
      end
    end
    e_upd = found && !flush;
    e_sq  = e_upd && m_mp[sel];
    if (e_upd) begin
      e_pc = m_pc[sel]; e_tk = m_tk[sel]; e_nx = m_nx[sel]; e_sqage = sage;
    end
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    end else begin
      if (e_upd) m_v[sel] = 1'b0;
      if (e_sq)
        for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_age[i] > sage) m_v[i] = 1'b0;
      if (vis_valid)
        for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
          if (m_pr[i] <= vis_root) m_pt[i] = 1'b0;
          if (m_tr[i] <= vis_root) m_tt[i] = 1'b0;
        end
      if (res_valid && cnt < DEPTH && !(e_sq && res_age > sage)) begin
        m_v[free_slot]   = 1'b1;
        m_age[free_slot] = res_age;
        m_pc[free_slot]  = res_pc;
        m_nx[free_slot]  = res_next;
        m_tk[free_slot]  = res_taken;
        m_mp[free_slot]  = res_mispred;
        m_pr[free_slot]  = res_pred_root;
        m_tr[free_slot]  = res_tgt_root;
        m_pt[free_slot]  = res_pred_tainted && !(vis_valid && res_pred_root <= vis_root);
        m_tt[free_slot]  = res_tgt_tainted && !(vis_valid && res_tgt_root <= vis_root);
      end
    end
  endtask

  always @(posedge clk) begin
    model_step();
    primed <= 1'b1;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (primed && !done) begin
      chk(cur_req, "upd_valid", 64'(upd_valid), 64'(e_upd));
      if (e_upd) begin
        chk(cur_req, "upd_pc", 64'(upd_pc), 64'(e_pc));
        chk(cur_req, "upd_taken", 64'(upd_taken), 64'(e_tk));
        chk(cur_req, "upd_next", 64'(upd_next), 64'(e_nx));
      end
      chk(cur_req, "sq_valid", 64'(sq_valid), 64'(e_sq));
      if (e_sq) begin
        chk(cur_req, "sq_age", 64'(sq_age), 64'(e_sqage));
        chk(cur_req, "sq_next", 64'(sq_next), 64'(e_nx));
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic set_res(input int age, input bit mp, input bit pt, input int pr,
                         input bit tt, input int tr);
    res_valid = 1'b1;
    res_age = AGE_W'(age);
    res_pc = ADDR_W'(32'h1000 + age * 16);
    res_next = ADDR_W'(32'h8000 + age * 4 + (mp ? 2 : 0));
    res_taken = age[0];
    res_mispred = mp;
    res_pred_tainted = pt; res_pred_root = ROOT_W'(pr);
    res_tgt_tainted = tt;  res_tgt_root = ROOT_W'(tr);
  endtask

  task automatic set_vis(input int root);
    vis_valid = 1'b1; vis_root = ROOT_W'(root);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      res_valid = 1'b0; vis_valid = 1'b0; flush = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    @(negedge clk);
    cur_req = "R1"; rst = 1'b1; tick(3); rst = 1'b0; tick(1);

    cur_req = "R9";  set_res(5, 0, 0, 0, 0, 0); tick(4);

    cur_req = "R2";  set_res(6, 0, 0, 0, 1, 10); tick(3);
    set_vis(9); tick(3); set_vis(10); tick(4);

    cur_req = "R10"; set_res(7, 0, 1, 3, 0, 0); set_vis(3); tick(4);

    cur_req = "R3";  set_res(8, 1, 1, 20, 0, 0); tick(4);
    set_vis(20); tick(4);

    cur_req = "R4";  set_res(10, 1, 1, 30, 0, 0); tick(1);
    set_res(12, 1, 0, 0, 0, 0); tick(4); set_vis(30); tick(4);

    cur_req = "R5";  set_res(20, 1, 1, 40, 0, 0); tick(1);
    set_res(22, 0, 1, 41, 0, 0); tick(1);
    set_res(24, 0, 0, 0, 1, 41); tick(1);
    set_res(18, 1, 0, 0, 0, 0); tick(4); set_vis(60); tick(4);

    cur_req = "R6";  set_res(33, 0, 0, 0, 1, 50); tick(1);
    set_res(31, 0, 0, 0, 1, 50); tick(1);
    set_res(35, 0, 0, 0, 1, 50); tick(1);
    set_res(30, 0, 0, 0, 1, 50); tick(1); set_vis(50); tick(6);

    cur_req = "R7";  set_res(40, 0, 1, 55, 0, 0); tick(1);
    set_res(44, 0, 1, 55, 0, 0); tick(1);
    set_res(42, 1, 1, 55, 0, 0); tick(1); set_vis(55); tick(5);

    cur_req = "R8";  set_res(50, 0, 1, 62, 0, 0); tick(1);
    set_res(51, 1, 0, 0, 1, 62); tick(1);
    set_res(52, 0, 0, 0, 0, 0); tick(1); flush = 1'b1; tick(1);
    set_vis(63); tick(4);

    cur_req = "R11"; set_res(60, 1, 0, 0, 1, 61); tick(1);
    set_vis(61); tick(1); set_res(62, 0, 0, 0, 0, 0); tick(4);
    set_res(57, 0, 0, 0, 0, 0); tick(4);

    cur_req = "R12";
    for (int a = 0; a < DEPTH; a++) begin set_res(a, a == 5, 1, 45, 0, 0); tick(1); end
    tick(2); set_vis(45); tick(DEPTH + 4);

    cur_req = "R6";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(63) == 0) flush = 1'b1;
      if ($urandom_range(3) == 0) set_vis(($urandom_range(7) == 0) ? 63 : int'($urandom_range(63)));
      if ($urandom_range(1) == 0 && model_count() < DEPTH) begin
        int a = int'($urandom_range(63));
        if (!age_busy(AGE_W'(a)))
          set_res(a, $urandom_range(3) == 0, $urandom_range(1) == 1, int'($urandom_range(63)),
                  $urandom_range(2) == 0, int'($urandom_range(63)));
      end
      tick(1);
    end
    flush = 1'b1; tick(3);
    summary();
  end

endmodule